// File: doc/BRIEF.md
# Byte Serializer with Selectable Lane Rate

This block turns a stream of parallel bytes into a serial bit stream, least significant bit first. A rate-select input picks between one serial bit per clock and two serial bits per clock. In single rate a byte takes eight clocks. In double rate it takes four clocks, and the two bits travel on a 2-bit output lane. A word clock marks the byte boundaries. Its period is always one byte, so eight serial bits make one word clock period at either rate.

A synchronizing input `sync` clears the block the moment it rises. It holds the block cleared while high. The first clock edge after it falls captures a fresh byte and starts the stream. A clock-enable input freezes the block on any edge where it is low, and the block resumes exactly where it stopped. The byte input and the rate select are sampled only at word boundaries. The caller may change them freely while a byte is being shifted out.

Top module: `ps_serializer`

## Requirements
- R1: While `sync` is high, `sout` reads 2'b00 and `wclk` reads 0. The first enabled rising edge after `sync` falls captures `din` and emits its bit 0.
- R2: With rate select low at the word boundary, each enabled edge emits one bit on `sout[0]` in the order bit 0 to bit 7, and `sout[1]` reads 0. One byte takes 8 enabled edges.
- R3: With rate select high at the word boundary, each enabled edge emits two bits. `sout[0]` carries the earlier bit (2k) and `sout[1]` carries bit 2k+1. One byte takes 4 enabled edges.
- R4: `wclk` is 1 while bits 0 to 3 of a byte are on `sout` and 0 while bits 4 to 7 are on `sout`. It therefore has one period per byte at either rate, and it changes only on enabled edges.
- R5: `din` is captured only at a word boundary. Changes to it during the remaining edges of a byte do not alter the bits emitted for that byte.
- R6: A change of rate select takes effect only at the next word boundary. No byte is emitted at mixed rates.
- R7: On a rising edge with `en` low, `sout`, `wclk` and the position within the byte all hold their values.
- R8: Raising `sync` in the middle of a byte abandons the rest of that byte. After `sync` falls, the stream restarts at bit 0 of a newly captured byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock, rising edge active |
| sync | input | 1 | Asynchronous clear. Conversion restarts after it falls |
| en | input | 1 | Synchronous conversion enable |
| rate_sel | input | 1 | 0: one bit per clock. 1: two bits per clock. Sampled at word boundaries |
| din | input | 8 | Parallel byte, sampled at word boundaries |
| sout | output | 2 | Serial lane. Bit 0 is the earlier bit. Bit 1 is used at double rate only |
| wclk | output | 1 | Word clock, one period per byte |

## Verification
The bench builds the block with its default parameters: an 8-bit word and a 2-bit lane. These give a half-word boundary at four bits and a counter whose wrap coincides with the byte boundary at both step sizes. This brings within reach every transition between the two rates, enable gaps inside a byte, and a mid-byte clear. Each case is compared clock by clock against a queue-based model of the serial stream.

// File: rtl/ps_pkg.sv
package ps_pkg;
    localparam int unsigned WORD_W = 8;
    localparam int unsigned LANE_W = 2;
    localparam int unsigned POS_W  = $clog2(WORD_W);
    localparam int unsigned HALF   = WORD_W / 2;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [POS_W-1:0]  pos_t;
    typedef logic [LANE_W-1:0] lane_t;

    typedef enum logic {RATE_SINGLE = 1'b0, RATE_DOUBLE = 1'b1} rate_e;

    // Bits leaving the holding word for the given position and rate.
    function automatic lane_t pick_lane(word_t w, pos_t p, rate_e r);
        lane_t l;
        l = '0;
        l[0] = w[p];
        if (r == RATE_DOUBLE) l[1] = w[p + pos_t'(1)];
        return l;
    endfunction

    function automatic pos_t step_of(rate_e r);
        return (r == RATE_DOUBLE) ? pos_t'(2) : pos_t'(1);
    endfunction
endpackage

// File: rtl/ps_word_ctrl.sv
module ps_word_ctrl
    import ps_pkg::*;
(
    input  logic  clk,
    input  logic  sync,
    input  logic  en,
    input  logic  rate_sel,
    output pos_t  pos,
    output logic  boundary,
    output rate_e rate_q,
    output logic  wclk
);
    assign boundary = (pos == '0);

    always_ff @(posedge clk or posedge sync) begin
        if (sync) begin
            pos    <= '0;
            rate_q <= RATE_SINGLE;
            wclk   <= 1'b0;
        end else if (en) begin
            if (boundary) begin
                rate_q <= rate_e'(rate_sel);
                pos    <= step_of(rate_e'(rate_sel));
                wclk   <= 1'b1;
            end else begin
                pos    <= pos + step_of(rate_q);
                wclk   <= (int'(pos) < HALF);
            end
        end
    end
endmodule

// File: rtl/ps_shift_lane.sv
module ps_shift_lane
    import ps_pkg::*;
(
    input  logic  clk,
    input  logic  sync,
    input  logic  en,
    input  logic  boundary,
    input  logic  rate_sel,
    input  rate_e rate_q,
    input  pos_t  pos,
    input  word_t din,
    output lane_t lane
);
    word_t hold;

    always_ff @(posedge clk or posedge sync) begin
        if (sync) begin
            hold <= '0;
            lane <= '0;
        end else if (en) begin
            if (boundary) begin
                hold <= din;
                lane <= pick_lane(din, '0, rate_e'(rate_sel));
            end else begin
                lane <= pick_lane(hold, pos, rate_q);
            end
        end
    end
endmodule

// File: rtl/ps_serializer.sv
module ps_serializer
    import ps_pkg::*;
(
    input  logic              clk,
    input  logic              sync,
    input  logic              en,
    input  logic              rate_sel,
    input  logic [WORD_W-1:0] din,
    output logic [LANE_W-1:0] sout,
    output logic              wclk
);
    pos_t  pos;
    logic  boundary;
    rate_e rate_q;

    ps_word_ctrl u_ctrl (
        .clk      (clk),
        .sync     (sync),
        .en       (en),
        .rate_sel (rate_sel),
        .pos      (pos),
        .boundary (boundary),
        .rate_q   (rate_q),
        .wclk     (wclk)
    );

    ps_shift_lane u_lane (
        .clk      (clk),
        .sync     (sync),
        .en       (en),
        .boundary (boundary),
        .rate_sel (rate_sel),
        .rate_q   (rate_q),
        .pos      (pos),
        .din      (din),
        .lane     (sout)
    );
endmodule

// File: rtl/ps_serializer_chk.sv
module ps_serializer_chk
    import ps_pkg::*;
(
    input logic  clk,
    input logic  sync,
    input logic  en,
    input lane_t sout,
    input logic  wclk,
    input pos_t  pos,
    input rate_e rate_q
);
    // R1: cleared outputs while sync is held high
    p_clear_r1: assert property (@(posedge clk) sync |-> (sout == '0 && !wclk));

    // R7: a disabled edge leaves outputs and position untouched
    p_hold_r7: assert property (@(posedge clk) disable iff (sync)
        !en |=> ($stable(sout) && $stable(wclk) && $stable(pos)));

    // R2: the upper lane bit stays quiet at single rate
    p_single_lane_r2: assert property (@(posedge clk) disable iff (sync)
        (rate_q == RATE_SINGLE) |-> (sout[1] == 1'b0));

    // R3: double rate always stands on an even bit position
    p_even_pos_r3: assert property (@(posedge clk) disable iff (sync)
        (rate_q == RATE_DOUBLE) |-> (pos[0] == 1'b0));

    // R6: the rate may change only across a word boundary
    p_rate_boundary_r6: assert property (@(posedge clk) disable iff (sync)
        !$stable(rate_q) |-> ($past(pos) == '0));

    // R4: the word clock moves only on enabled edges
    p_wclk_enabled_r4: assert property (@(posedge clk) disable iff (sync)
        !$stable(wclk) |-> $past(en));
endmodule

bind ps_serializer ps_serializer_chk i_chk (
    .clk    (clk),
    .sync   (sync),
    .en     (en),
    .sout   (sout),
    .wclk   (wclk),
    .pos    (pos),
    .rate_q (rate_q)
);

// File: tb/test_ps_serializer.sv
module test_ps_serializer;
    logic       clk = 1'b0;
    logic       sync = 1'b1;
    logic       en = 1'b0;
    logic       rate_sel = 1'b0;
    logic [7:0] din = 8'h00;
    logic [1:0] sout;
    logic       wclk;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // behavioural model
    bit   m_q[$];
    bit   m_dbl = 1'b0;
    logic [1:0] m_sout = 2'b00;
    logic       m_wclk = 1'b0;

    always #4 clk = ~clk;

    ps_serializer i_ps_serializer (
        .clk(clk), .sync(sync), .en(en), .rate_sel(rate_sel),
        .din(din), .sout(sout), .wclk(wclk)
    );

    always @(posedge clk) begin
        if (sync) begin
            m_q.delete();
            m_sout = 2'b00;
            m_wclk = 1'b0;
        end else if (en) begin
            if (m_q.size() == 0) begin
                for (int i = 0; i < 8; i++) m_q.push_back(din[i]);
                m_dbl = rate_sel;
            end
            m_wclk    = (m_q.size() > 4);
            m_sout[0] = m_q.pop_front();
            m_sout[1] = m_dbl ? m_q.pop_front() : 1'b0;
        end
    end

    task automatic check(string req, logic [1:0] exp_s, logic exp_w);
        n_checks++;
        if (sout !== exp_s || wclk !== exp_w) begin
            n_fail++;
            $display("FAIL %s: sout=%b wclk=%b expected sout=%b wclk=%b",
                     req, sout, wclk, exp_s, exp_w);
        end
    endtask

    // one clock: compare after the previous edge, then drive new inputs
    task automatic cyc(bit e, bit r, logic [7:0] d);
        @(negedge clk);
        check(cur_req, m_sout, m_wclk);
        en = e; rate_sel = r; din = d;
    endtask

    initial begin
        #1;
        cur_req = "R1";
        cyc(1, 0, 8'hA5);
        cyc(1, 0, 8'hA5);
        @(negedge clk); sync = 1'b0;
        cur_req = "R2";
        for (int i = 0; i < 16; i++) cyc(1, 0, (i < 8) ? 8'h3C : 8'hD2);
        cur_req = "R3";
        for (int i = 0; i < 12; i++) cyc(1, 1, 8'h96 + 8'(i));
        cur_req = "R5";
        for (int i = 0; i < 16; i++) cyc(1, i[0], 8'(i * 37));
        cur_req = "R6";
        for (int i = 0; i < 24; i++) cyc(1, (i % 3) == 1, 8'h5A ^ 8'(i));
        cur_req = "R7";
        for (int i = 0; i < 30; i++) cyc((i % 4) != 2, (i / 7) % 2 == 1, 8'hC3 + 8'(i));
        cur_req = "R4";
        for (int i = 0; i < 20; i++) cyc(1, i >= 8, 8'h81);
        cur_req = "R8";
        cyc(1, 0, 8'hF0);
        cyc(1, 0, 8'hF0);
        cyc(1, 0, 8'hF0);
        @(negedge clk); sync = 1'b1;
        cyc(1, 1, 8'h6B);
        cyc(1, 1, 8'h6B);
        @(negedge clk); sync = 1'b0;
        for (int i = 0; i < 10; i++) cyc(1, 1, 8'h6B);
        cur_req = "R1";
        cyc(1, 0, 8'h00);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: timeout actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule